// File: doc/BRIEF.md
# Thread Block Dispatch Scheduler

This block hands the numbered thread blocks of one kernel launch to a small array of compute cores. A launch command gives how many blocks exist, how many thread contexts each block occupies and how many bytes of on-core shared storage each block reserves. Each core offers a fixed pool of thread contexts and a fixed pool of shared storage. The scheduler carves both pools into equal per-block slots whose size is set by the launch. A block is issued to a core only when a slot there fits in both pools at once.

Each issue names the core, the slot, the block number, the base of the block's context range and the base of its shared-storage region. A core returns a slot by pulsing its retire line with the slot index. The freed slot, with exactly the same context range and storage offset, becomes available to the next block. At most one block is issued per clock. When more than one core can take a block, a rotating pointer picks the core that follows the last one served, so blocks spread across the cores in turn. The kernel is reported done once every block has been issued and none is still resident. A new launch is taken only in that state.

Top module: `tbd_block_dispatch`

## Requirements
- R1: During and directly after synchronous active-low reset, `issue_valid` is 0, `kernel_done` is 1 and `retire_error` is 0.
- R2: A launch is accepted only in a cycle where `kernel_done` is 1. A launch pulse while blocks are outstanding is ignored and changes neither the block count nor the sizes.
- R3: Slot s (counting from 0, below MAX_SLOTS) on a core is usable only if (s+1)·threads ≤ CTX_PER_CORE and (s+1)·bytes ≤ SHM_PER_CORE. With 128 threads and 520 bytes, a core holds two blocks. With 128 and 256 it holds three. With 256 and 100 it holds one.
- R4: An issued block takes the lowest free usable slot of its core. Its context base is slot·threads and its shared base is slot·bytes.
- R5: Block numbers start at 0 after a launch and rise by one per issue. Issuing stops once the count issued equals the launch count; a count of 0 issues nothing.
- R6: At most one block is issued per clock, as a one-cycle `issue_valid` pulse one clock after the decision. Among cores that can accept, the first one after the last core served (cyclically) wins. After reset or a launch, core 0 is tried first.
- R7: A retire pulse on core c with slot index s frees that slot. The next block placed on that core reuses exactly that context base and shared offset.
- R8: A retire naming a slot that is not resident (or an index ≥ MAX_SLOTS) changes no state and sets `retire_error`, which stays 1 until reset.
- R9: `kernel_done` is 1 exactly when every block of the launch has been issued and no slot on any core is resident.
- R10: Reset mid-kernel drops all resident slots and the pending count, so the block is idle and ready for a launch, with core 0 served first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| launch_valid | input | 1 | Launch command strobe |
| launch_blocks | input | BLK_W | Number of blocks in the kernel |
| launch_threads | input | CTX_W | Thread contexts per block |
| launch_bytes | input | SHM_W | Shared-storage bytes per block |
| retire_valid | input | NUM_CORES | Per-core slot-retire pulse |
| retire_slot | input | NUM_CORES*SLOT_W | Per-core retired slot index, core c at bits [c*SLOT_W +: SLOT_W] |
| issue_valid | output | 1 | A block is issued this cycle |
| issue_core | output | CORE_W | Target core of the issued block |
| issue_slot | output | SLOT_W | Slot index on that core |
| issue_block | output | BLK_W | Block number |
| issue_ctx_base | output | CTX_W | First thread context of the block |
| issue_shm_base | output | SHM_W | Byte offset of the block's shared region |
| kernel_done | output | 1 | All blocks issued and none resident |
| retire_error | output | 1 | Sticky flag for a retire of a non-resident slot |

## Verification
The bench uses the default build: two cores, 384 contexts and 1536 bytes per core, and three slots per core. With these values the pools can limit residency in three ways from the launch sizes alone. With 520-byte blocks the storage pool caps a core at two blocks while contexts remain free. With 256-byte blocks all three slots fill. With 256-thread blocks the context pool caps a core at one block. Two cores are enough to show that issues alternate between cores and that a single accepting core takes the block regardless of the pointer.

// File: rtl/tbd_pkg.sv
package tbd_pkg;
   // index width of a field that selects one of n items, at least one bit
   function automatic int idx_w(input int n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

   // width of a field that holds values 0..n
   function automatic int cnt_w(input int n);
      return (n <= 1) ? 1 : $clog2(n + 1);
   endfunction
endpackage

// File: rtl/tbd_core_slots.sv
module tbd_core_slots #(
   parameter int MAX_SLOTS    = 3,
   parameter int CTX_PER_CORE = 384,
   parameter int SHM_PER_CORE = 1536,
   parameter int CTX_W        = 9,
   parameter int SHM_W        = 11,
   parameter int SLOT_W       = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CTX_W-1:0]  thr,
   input  logic [SHM_W-1:0]  shm,
   input  logic              take,
   input  logic              rel,
   input  logic [SLOT_W-1:0] rel_slot,
   output logic              can_take,
   output logic [SLOT_W-1:0] take_slot,
   output logic              occupied,
   output logic              rel_bad
);
   logic [MAX_SLOTS-1:0] live_q;
   logic [MAX_SLOTS-1:0] fits;
   logic [MAX_SLOTS-1:0] rel_mask;
   logic [MAX_SLOTS-1:0] take_mask;

   for (genvar s = 0; s < MAX_SLOTS; s++) begin : g_slot
      assign fits[s]      = (32'(s + 1) * 32'(thr) <= 32'(CTX_PER_CORE)) &&
                            (32'(s + 1) * 32'(shm) <= 32'(SHM_PER_CORE));
      assign rel_mask[s]  = rel && (32'(rel_slot) == 32'(s));
      assign take_mask[s] = take && (32'(take_slot) == 32'(s));
   end

   always_comb begin
      can_take  = 1'b0;
      take_slot = '0;
      for (int s = MAX_SLOTS - 1; s >= 0; s--) begin
         if (!live_q[s] && fits[s]) begin
            can_take  = 1'b1;
            take_slot = SLOT_W'(s);
         end
      end
   end

   assign occupied = |live_q;
   assign rel_bad  = rel && ((rel_mask & live_q) == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) live_q <= '0;
      else        live_q <= (live_q & ~rel_mask) | take_mask;
   end
endmodule

// File: rtl/tbd_rr_pick.sv
module tbd_rr_pick #(
   parameter int N  = 2,
   parameter int IW = 1
) (
   input  logic [N-1:0]  req,
   input  logic [IW-1:0] last,
   output logic          hit,
   output logic [IW-1:0] idx
);
   always_comb begin
      hit = 1'b0;
      idx = last;
      for (int k = N; k >= 1; k--) begin
         if (req[(int'(last) + k) % N]) begin
            hit = 1'b1;
            idx = IW'((int'(last) + k) % N);
         end
      end
   end
endmodule

// File: rtl/tbd_block_dispatch.sv
module tbd_block_dispatch #(
   parameter int NUM_CORES    = 2,
   parameter int MAX_SLOTS    = 3,
   parameter int CTX_PER_CORE = 384,
   parameter int SHM_PER_CORE = 1536,
   parameter int BLK_W        = 16,
   localparam int CORE_W      = tbd_pkg::idx_w(NUM_CORES),
   localparam int SLOT_W      = tbd_pkg::idx_w(MAX_SLOTS),
   localparam int CTX_W       = tbd_pkg::cnt_w(CTX_PER_CORE),
   localparam int SHM_W       = tbd_pkg::cnt_w(SHM_PER_CORE)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        launch_valid,
   input  logic [BLK_W-1:0]            launch_blocks,
   input  logic [CTX_W-1:0]            launch_threads,
   input  logic [SHM_W-1:0]            launch_bytes,
   input  logic [NUM_CORES-1:0]        retire_valid,
   input  logic [NUM_CORES*SLOT_W-1:0] retire_slot,
   output logic                        issue_valid,
   output logic [CORE_W-1:0]           issue_core,
   output logic [SLOT_W-1:0]           issue_slot,
   output logic [BLK_W-1:0]            issue_block,
   output logic [CTX_W-1:0]            issue_ctx_base,
   output logic [SHM_W-1:0]            issue_shm_base,
   output logic                        kernel_done,
   output logic                        retire_error
);
   if (NUM_CORES < 1 || MAX_SLOTS < 1 || CTX_PER_CORE < 1 || SHM_PER_CORE < 1 || BLK_W < 1)
   begin : g_bad_cfg
      $error("tbd_block_dispatch: every size parameter must be at least 1");
   end

   logic [BLK_W-1:0]  total_q, next_q;
   logic [CTX_W-1:0]  thr_q;
   logic [SHM_W-1:0]  shm_q;
   logic [CORE_W-1:0] last_q;

   logic [NUM_CORES-1:0] can, occ, bad, take;
   logic [SLOT_W-1:0]    slot_of [NUM_CORES];
   logic                 pending, fire, launch_ok;
   logic [CORE_W-1:0]    sel;
   logic [SLOT_W-1:0]    sel_slot;

   assign pending = (next_q != total_q);

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      assign take[c] = fire && (32'(sel) == 32'(c));
      tbd_core_slots #(
         .MAX_SLOTS(MAX_SLOTS), .CTX_PER_CORE(CTX_PER_CORE), .SHM_PER_CORE(SHM_PER_CORE),
         .CTX_W(CTX_W), .SHM_W(SHM_W), .SLOT_W(SLOT_W)
      ) i_slots (
         .clk(clk), .rst_n(rst_n), .thr(thr_q), .shm(shm_q),
         .take(take[c]), .rel(retire_valid[c]), .rel_slot(retire_slot[c*SLOT_W +: SLOT_W]),
         .can_take(can[c]), .take_slot(slot_of[c]), .occupied(occ[c]), .rel_bad(bad[c])
      );
   end

   tbd_rr_pick #(.N(NUM_CORES), .IW(CORE_W)) i_pick (
      .req(can & {NUM_CORES{pending}}), .last(last_q), .hit(fire), .idx(sel)
   );

   assign sel_slot    = slot_of[sel];
   assign kernel_done = !pending && (occ == '0);
   assign launch_ok   = launch_valid && kernel_done;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         total_q        <= '0;
         next_q         <= '0;
         thr_q          <= '0;
         shm_q          <= '0;
         last_q         <= CORE_W'(NUM_CORES - 1);
         issue_valid    <= 1'b0;
         issue_core     <= '0;
         issue_slot     <= '0;
         issue_block    <= '0;
         issue_ctx_base <= '0;
         issue_shm_base <= '0;
         retire_error   <= 1'b0;
      end else begin
         issue_valid <= fire;
         if (fire) begin
            issue_core     <= sel;
            issue_slot     <= sel_slot;
            issue_block    <= next_q;
            issue_ctx_base <= CTX_W'(32'(sel_slot) * 32'(thr_q));
            issue_shm_base <= SHM_W'(32'(sel_slot) * 32'(shm_q));
            next_q         <= next_q + 1'b1;
            last_q         <= sel;
         end
         if (|bad) retire_error <= 1'b1;
         if (launch_ok) begin
            total_q <= launch_blocks;
            next_q  <= '0;
            thr_q   <= launch_threads;
            shm_q   <= launch_bytes;
            last_q  <= CORE_W'(NUM_CORES - 1);
         end
      end
   end
endmodule

// File: rtl/tbd_block_dispatch_chk.sv
module tbd_block_dispatch_chk #(
   parameter int NUM_CORES    = 2,
   parameter int CTX_PER_CORE = 384,
   parameter int SHM_PER_CORE = 1536,
   parameter int BLK_W        = 16,
   parameter int CORE_W       = 1,
   parameter int CTX_W        = 9,
   parameter int SHM_W        = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              issue_valid,
   input logic [CORE_W-1:0] issue_core,
   input logic [BLK_W-1:0]  issue_block,
   input logic [CTX_W-1:0]  issue_ctx_base,
   input logic [SHM_W-1:0]  issue_shm_base,
   input logic              kernel_done,
   input logic              retire_error,
   input logic [CTX_W-1:0]  thr_q,
   input logic [SHM_W-1:0]  shm_q
);
   // R1
   reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !issue_valid && !retire_error);

   // R3
   ctx_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> (32'(issue_ctx_base) + 32'(thr_q) <= 32'(CTX_PER_CORE)));

   // R3
   shm_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> (32'(issue_shm_base) + 32'(shm_q) <= 32'(SHM_PER_CORE)));

   // R5
   block_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid && $past(issue_valid) |-> issue_block == $past(issue_block) + 1'b1);

   // R6
   core_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> 32'(issue_core) < 32'(NUM_CORES));

   // R8
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      retire_error |=> retire_error);

   // R9
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kernel_done |-> !issue_valid);
endmodule

bind tbd_block_dispatch tbd_block_dispatch_chk #(
   .NUM_CORES(NUM_CORES), .CTX_PER_CORE(CTX_PER_CORE), .SHM_PER_CORE(SHM_PER_CORE),
   .BLK_W(BLK_W), .CORE_W(CORE_W), .CTX_W(CTX_W), .SHM_W(SHM_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_core(issue_core),
   .issue_block(issue_block), .issue_ctx_base(issue_ctx_base), .issue_shm_base(issue_shm_base),
   .kernel_done(kernel_done), .retire_error(retire_error), .thr_q(thr_q), .shm_q(shm_q)
);

// File: tb/test_tbd_block_dispatch.sv
module test_tbd_block_dispatch;
   localparam int NC  = 2;
   localparam int MS  = 3;
   localparam int CTX = 384;
   localparam int SHM = 1536;
   localparam int BW  = 16;
   localparam int CW  = 1;
   localparam int SW  = 2;
   localparam int XW  = 9;
   localparam int HW  = 11;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic launch_valid = 1'b0;
   logic [BW-1:0] launch_blocks = '0;
   logic [XW-1:0] launch_threads = '0;
   logic [HW-1:0] launch_bytes = '0;
   logic [NC-1:0] retire_valid = '0;
   logic [NC*SW-1:0] retire_slot = '0;
   logic issue_valid, kernel_done, retire_error;
   logic [CW-1:0] issue_core;
   logic [SW-1:0] issue_slot;
   logic [BW-1:0] issue_block;
   logic [XW-1:0] issue_ctx_base;
   logic [HW-1:0] issue_shm_base;

   always #4 clk = ~clk;

   tbd_block_dispatch #(.NUM_CORES(NC), .MAX_SLOTS(MS), .CTX_PER_CORE(CTX),
                        .SHM_PER_CORE(SHM), .BLK_W(BW)) i_tbd_block_dispatch (
      .clk(clk), .rst_n(rst_n), .launch_valid(launch_valid), .launch_blocks(launch_blocks),
      .launch_threads(launch_threads), .launch_bytes(launch_bytes),
      .retire_valid(retire_valid), .retire_slot(retire_slot),
      .issue_valid(issue_valid), .issue_core(issue_core), .issue_slot(issue_slot),
      .issue_block(issue_block), .issue_ctx_base(issue_ctx_base), .issue_shm_base(issue_shm_base),
      .kernel_done(kernel_done), .retire_error(retire_error)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;
   bit cmp_on = 1'b0;

   // reference model state
   bit m_occ [NC][MS];
   int m_total, m_next, m_thr, m_shm, m_last;
   bit m_err;
   bit e_valid;
   int e_core, e_slot, e_block, e_ctx, e_shm;

   // dispatch log seen at the ports
   int n_issue = 0;
   int log_core [64];
   int log_ctx  [64];
   int log_shm  [64];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int free_slot(input int c);
      for (int s = 0; s < MS; s++)
         if (!m_occ[c][s] && (s + 1) * m_thr <= CTX && (s + 1) * m_shm <= SHM) return s;
      return -1;
   endfunction

   function automatic bit m_busy();
      for (int c = 0; c < NC; c++)
         for (int s = 0; s < MS; s++)
            if (m_occ[c][s]) return 1'b1;
      return 1'b0;
   endfunction

   function automatic bit m_done();
      return (m_next >= m_total) && !m_busy();
   endfunction

   always @(posedge clk) begin
      automatic int dc = -1;
      automatic int ds = -1;
      automatic int cc;
      automatic int fs;
      automatic int rs;
      automatic bit idle;
      if (!rst_n) begin
         for (int c = 0; c < NC; c++)
            for (int s = 0; s < MS; s++) m_occ[c][s] = 1'b0;
         m_total = 0; m_next = 0; m_thr = 0; m_shm = 0; m_last = NC - 1;
         m_err = 1'b0; e_valid = 1'b0;
      end else begin
         idle = m_done();
         if (m_next < m_total)
            for (int k = 1; k <= NC; k++) begin
               cc = (m_last + k) % NC;
               fs = free_slot(cc);
               if (dc < 0 && fs >= 0) begin dc = cc; ds = fs; end
            end
         for (int c = 0; c < NC; c++)
            if (retire_valid[c]) begin
               rs = int'(retire_slot[c*SW +: SW]);
               if (rs < MS && m_occ[c][rs]) m_occ[c][rs] = 1'b0;
               else m_err = 1'b1;
            end
         if (launch_valid && idle) begin
            m_total = int'(launch_blocks); m_next = 0;
            m_thr = int'(launch_threads); m_shm = int'(launch_bytes); m_last = NC - 1;
         end
         e_valid = (dc >= 0);
         if (dc >= 0) begin
            m_occ[dc][ds] = 1'b1;
            e_core = dc; e_slot = ds; e_block = m_next;
            e_ctx = ds * m_thr; e_shm = ds * m_shm;
            m_next++; m_last = dc;
         end
      end
   end

   // per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (cmp_on && !finished) begin
         chk(issue_valid == e_valid, "R6 issue_valid", int'(issue_valid), int'(e_valid));
         if (issue_valid && e_valid) begin
            chk(int'(issue_core) == e_core, "R6 issue_core", int'(issue_core), e_core);
            chk(int'(issue_block) == e_block, "R5 issue_block", int'(issue_block), e_block);
            chk(int'(issue_slot) == e_slot, "R4 issue_slot", int'(issue_slot), e_slot);
            chk(int'(issue_ctx_base) == e_ctx, "R4 ctx_base", int'(issue_ctx_base), e_ctx);
            chk(int'(issue_shm_base) == e_shm, "R4 shm_base", int'(issue_shm_base), e_shm);
         end
         chk(kernel_done == m_done(), "R9 kernel_done", int'(kernel_done), int'(m_done()));
         chk(retire_error == m_err, "R8 retire_error", int'(retire_error), int'(m_err));
      end
      if (issue_valid) begin
         n_issue++;
         log_core[issue_block % 64] = int'(issue_core);
         log_ctx[issue_block % 64]  = int'(issue_ctx_base);
         log_shm[issue_block % 64]  = int'(issue_shm_base);
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic launch(input int b, input int t, input int s);
      @(negedge clk);
      launch_valid = 1'b1; launch_blocks = BW'(b); launch_threads = XW'(t); launch_bytes = HW'(s);
      @(negedge clk);
      launch_valid = 1'b0;
   endtask

   task automatic retire(input int c, input int s);
      @(negedge clk);
      retire_valid[c] = 1'b1; retire_slot[c*SW +: SW] = SW'(s);
      @(negedge clk);
      retire_valid = '0;
   endtask

   task automatic drain();
      for (int c = 0; c < NC; c++)
         for (int s = 0; s < MS; s++)
            if (m_occ[c][s]) retire(c, s);
      tick(3);
   endtask

   initial begin
      int base;
      tick(3);
      cmp_on = 1'b1;
      // r1_ reset state
      chk(issue_valid == 1'b0, "R1 issue_valid in reset", int'(issue_valid), 0);
      chk(kernel_done == 1'b1, "R1 kernel_done in reset", int'(kernel_done), 1);
      chk(retire_error == 1'b0, "R1 retire_error in reset", int'(retire_error), 0);
      rst_n = 1'b1;
      tick(2);

      // 128 threads / 520 bytes: storage caps each core at two blocks
      launch(6, 128, 520);
      tick(6);
      chk(n_issue == 4, "R3 two blocks per core at 520 bytes", n_issue, 4);
      chk(log_core[2] == 0 && log_core[3] == 1, "R6 interleaved cores", log_core[2], 0);
      chk(log_ctx[3] == 128, "R4 second slot context base", log_ctx[3], 128);
      chk(log_shm[3] == 520, "R4 second slot shared base", log_shm[3], 520);

      // launch while busy must be ignored
      launch(9, 64, 64);
      retire(0, 0);
      tick(3);
      chk(n_issue == 5, "R7 one block after one retire", n_issue, 5);
      chk(log_core[4] == 0 && log_ctx[4] == 0, "R7 reused context base", log_ctx[4], 0);
      chk(log_shm[4] == 0, "R7 reused shared offset", log_shm[4], 0);

      // retire of a free slot
      retire(1, 2);
      tick(2);
      chk(retire_error == 1'b1, "R8 bad retire flagged", int'(retire_error), 1);
      chk(n_issue == 5, "R8 bad retire frees nothing", n_issue, 5);

      retire(1, 1);
      tick(3);
      chk(log_core[5] == 1 && log_ctx[5] == 128, "R7 core1 slot1 reused", log_ctx[5], 128);
      drain();
      chk(n_issue == 6, "R2 busy launch ignored, six blocks total", n_issue, 6);
      chk(kernel_done == 1'b1, "R9 done after drain", int'(kernel_done), 1);
      chk(retire_error == 1'b1, "R8 flag stays set", int'(retire_error), 1);

      // 128 / 256: three per core
      base = n_issue;
      launch(7, 128, 256);
      tick(8);
      chk(n_issue - base == 6, "R3 three blocks per core at 256 bytes", n_issue - base, 6);
      chk(log_ctx[4] == 256 && log_shm[4] == 512, "R4 third slot bases", log_shm[4], 512);
      retire(1, 0);
      tick(3);
      chk(log_core[6] == 1, "R6 only accepting core wins", log_core[6], 1);
      drain();
      chk(n_issue - base == 7, "R5 stop at launch count", n_issue - base, 7);

      // 256 threads: contexts cap each core at one
      base = n_issue;
      launch(3, 256, 100);
      tick(5);
      chk(n_issue - base == 2, "R3 one block per core at 256 threads", n_issue - base, 2);

      // r10_ reset mid-kernel
      @(negedge clk); rst_n = 1'b0;
      tick(2);
      rst_n = 1'b1;
      tick(1);
      chk(kernel_done == 1'b1, "R10 idle after mid-kernel reset", int'(kernel_done), 1);
      chk(retire_error == 1'b0, "R10 flag cleared", int'(retire_error), 0);

      base = n_issue;
      launch(0, 128, 520);
      tick(3);
      chk(n_issue == base && kernel_done, "R5 zero-block launch", n_issue - base, 0);

      launch(2, 128, 520);
      tick(4);
      chk(log_core[0] == 0 && log_core[1] == 1, "R6 core0 first after launch", log_core[0], 0);
      drain();
      chk(kernel_done == 1'b1, "R9 final done", int'(kernel_done), 1);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule